// File: doc/BRIEF.md
# Event Timer Register Front End

This block is the register side and the free-running time base of a three-channel event timer. A host issues single 32-bit reads and writes into a 1 KB address window. The block holds a capability word pair, a global control word, an interrupt status word and a 64-bit tick counter. It also contains the comparator channels that sit behind the per-channel registers. When a channel's comparator matches the counter, the block drives a one-cycle pulse on one of its interrupt output lines. The channel's route field picks that line. A legacy option instead fixes the lines used by channels 0 and 1, and it tells an external legacy tick source to switch off.

Requests use a valid/ready handshake. `req_ready` is always high, so the block applies no back-pressure and accepts one request on every cycle that `req_valid` is high. A read produces `rsp_valid` for exactly one cycle on the cycle after acceptance, and the response cannot be stalled. Write requests produce no response. The low two address bits are ignored.

The counter advances by one per clock only while the global enable bit is set. When the enable bit is clear, the counter holds its value and software may load either 32-bit half.

Top module: `evt_timer_regif`

## Requirements
- R1: After reset the registers read as follows. Offset 0x000 reads 0x8086A201, which encodes 3 channels, a 64-bit counter and legacy capability. Offset 0x004 reads the tick period parameter. Offsets 0x010, 0x020, 0x0F0 and 0x0F4 read zero. For each channel n, at base 0x100+0x20*n: +0x0 reads 0x30, +0x4 reads the route capability mask 0x00FFFFFF, and +0x8 and +0xC read 0xFFFFFFFF. `legacy_off` and `irq_pulse` are low.
- R2: `req_ready` is always 1. Every accepted read gives `rsp_valid` high for exactly the next cycle, carrying the register value at acceptance. Writes give no response.
- R3: Any offset that is not listed in R1, including channel slots from index 3 up to 0x3FF, reads zero. A write to such an offset changes nothing.
- R4: An access whose `req_size` is not 2 (0 = byte, 1 = halfword) is ignored. A write of this kind changes nothing. A read of this kind still responds, with data zero.
- R5: In the global control word at 0x010, only bit 0 (enable) and bit 1 (legacy) can be written. All other bits read zero, and 0x014 reads zero.
- R6: While enable is 1, the counter increases by exactly 1 per clock. While enable is 0, it holds its value, and reads return the held value.
- R7: The counter's low half (0x0F0) and high half (0x0F4) are written independently. A write to one half leaves the other half unchanged.
- R8: Writes to 0x000, 0x004 and 0x020 are ignored. The status word at 0x020 always reads zero, because only edge delivery is supported.
- R9: In a channel control word, the writable bits are 2 (interrupt enable), 3 (periodic), 6 (set-comparator), 8 (32-bit mode) and 13:9 (route). Bits 5:4 always read 1. Bit 1 and all other bits read 0. The +0x4 word is read-only.
- R10: A one-shot channel that is armed fires once when the counter equals its comparator. If its interrupt enable is set, the firing appears as a single-cycle pulse on its route line, on the cycle after the match. A channel whose interrupt enable is clear produces no pulse.
- R11: For a periodic channel, a write to comparator-low sets the period. If set-comparator is 1, or if the channel is not periodic, that write also sets the comparator. The write then clears set-comparator. Each match adds the period to the comparator, so pulses repeat every period clocks.
- R12: When enable changes from 0 to 1, every channel whose comparator is not all ones is armed. When enable changes from 1 to 0, all channels are disarmed and no pulse follows.
- R13: While legacy (bit 1) is set, channel 0 pulses line 0 and channel 1 pulses line 8, whatever their route fields hold. `legacy_off` equals the legacy bit from the cycle after the write.
- R14: Setting 32-bit mode clears the upper halves of the comparator and the period. In 32-bit mode, writes to comparator-high are ignored, and a match compares only the low 32 counter bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready, always 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| req_addr | input | 10 | Byte offset within the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 32 | Read data |
| irq_pulse | output | 24 | Interrupt line pulses |
| legacy_off | output | 1 | Request to switch the legacy tick source off |

## Verification
The bench reads every word offset in the window, once after reset and again after a set of narrow, read-only and out-of-range writes. A decoder that aliases channel slot 3 onto a real channel, or that honours byte writes, would show a changed word in that sweep. Pulse timing is counted in clocks from the enable write and compared with the comparator minus the starting counter value. An off-by-one in the arming or match pipeline would therefore move the pulse by one cycle. Periodic reload is checked by the spacing of the pulses and by the final comparator value. Legacy routing is run with and without the legacy bit, so a router that ignores the bit puts the pulse on lines 3 and 4 instead of lines 0 and 8. The 32-bit case starts the counter with a nonzero upper half, so a full-width compare would never fire.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  localparam int WORD_W = 32;
  localparam int ADDR_W = 10;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  // Global area offsets (byte address, word aligned)
  localparam logic [ADDR_W-1:0] OFS_CAP_LO = 10'h000;
  localparam logic [ADDR_W-1:0] OFS_CAP_HI = 10'h004;
  localparam logic [ADDR_W-1:0] OFS_GCTL   = 10'h010;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 10'h020;
  localparam logic [ADDR_W-1:0] OFS_CNT_LO = 10'h0F0;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI = 10'h0F4;

  // Channel area: slot = addr[9:5] - CH_SLOT0, word = addr[4:2]
  localparam logic [4:0] CH_SLOT0 = 5'd8;
  localparam logic [2:0] SUB_CTL_LO = 3'd0;
  localparam logic [2:0] SUB_CTL_HI = 3'd1;
  localparam logic [2:0] SUB_CMP_LO = 3'd2;
  localparam logic [2:0] SUB_CMP_HI = 3'd3;

  localparam int GCTL_EN  = 0;
  localparam int GCTL_LEG = 1;

  localparam logic [4:0] LEG_LINE_CH0 = 5'd0;
  localparam logic [4:0] LEG_LINE_CH1 = 5'd8;

  typedef struct packed {
    logic [4:0] route;
    logic       mode32;
    logic       set_cmp;
    logic       periodic;
    logic       irq_en;
  } chan_ctl_t;

  function automatic chan_ctl_t ctl_from_word(input logic [WORD_W-1:0] w);
    chan_ctl_t c;
    c.irq_en   = w[2];
    c.periodic = w[3];
    c.set_cmp  = w[6];
    c.mode32   = w[8];
    c.route    = w[13:9];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] ctl_to_word(input chan_ctl_t c);
    return {18'b0, c.route, c.mode32, 1'b0, c.set_cmp, 2'b11, c.periodic, c.irq_en, 2'b00};
  endfunction

endpackage

// File: rtl/evt_timer_counter.sv
module evt_timer_counter #(
  parameter int CNT_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [CNT_W/2-1:0] wdata,
  output logic [CNT_W-1:0]   count
);
  localparam int HW = CNT_W / 2;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      if (wr_lo) cnt_q[HW-1:0] <= wdata;
      if (wr_hi) cnt_q[CNT_W-1:HW] <= wdata;
      if (!wr_lo && !wr_hi && run) cnt_q <= cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/evt_timer_channel.sv
module evt_timer_channel
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_we,
  input  logic               cmp_lo_we,
  input  logic               cmp_hi_we,
  input  logic [CNT_W/2-1:0] wdata,
  input  logic               glb_en,
  input  logic               en_rise,
  input  logic               en_fall,
  input  logic [CNT_W-1:0]   count,
  output logic [WORD_W-1:0]  ctl_word,
  output logic [CNT_W-1:0]   cmp_val,
  output logic               fire,
  output logic [4:0]         route
);
  localparam int HW = CNT_W / 2;

  chan_ctl_t        ctl_q;
  chan_ctl_t        ctl_new;
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] per_q;
  logic [CNT_W-1:0] cmp_step;
  logic             armed_q;
  logic             match;
  logic             fire_q;
  logic             load_cmp;

  always_comb begin
    if (ctl_q.mode32) match = armed_q && glb_en && (count[HW-1:0] == cmp_q[HW-1:0]);
    else              match = armed_q && glb_en && (count == cmp_q);
  end

  always_comb begin
    if (ctl_q.mode32) cmp_step = {{HW{1'b0}}, cmp_q[HW-1:0] + per_q[HW-1:0]};
    else              cmp_step = cmp_q + per_q;
  end

  assign ctl_new  = ctl_from_word(wdata);
  assign load_cmp = !ctl_q.periodic || ctl_q.set_cmp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      cmp_q   <= '1;
      per_q   <= '0;
      armed_q <= 1'b0;
      fire_q  <= 1'b0;
    end else begin
      fire_q <= match && ctl_q.irq_en;
      if (match) begin
        if (ctl_q.periodic && (per_q != '0)) cmp_q <= cmp_step;
        else armed_q <= 1'b0;
      end
      if (en_rise) armed_q <= (cmp_q != '1);
      if (en_fall) armed_q <= 1'b0;
      if (ctl_we) begin
        ctl_q <= ctl_new;
        if (ctl_new.mode32) begin
          cmp_q[CNT_W-1:HW] <= '0;
          per_q[CNT_W-1:HW] <= '0;
        end
      end
      if (cmp_lo_we) begin
        if (load_cmp) cmp_q[HW-1:0] <= wdata;
        if (ctl_q.periodic) begin
          if (ctl_q.mode32) per_q[HW-1:0] <= {1'b0, wdata[HW-2:0]};
          else              per_q[HW-1:0] <= wdata;
        end
        ctl_q.set_cmp <= 1'b0;
        armed_q       <= glb_en;
      end
      if (cmp_hi_we && !ctl_q.mode32) begin
        if (load_cmp) cmp_q[CNT_W-1:HW] <= wdata;
        else          per_q[CNT_W-1:HW] <= {1'b0, wdata[HW-2:0]};
        ctl_q.set_cmp <= 1'b0;
        armed_q       <= glb_en;
      end
    end
  end

  assign ctl_word = ctl_to_word(ctl_q);
  assign cmp_val  = cmp_q;
  assign fire     = fire_q;
  assign route    = ctl_q.route;
endmodule

// File: rtl/evt_timer_irq_router.sv
module evt_timer_irq_router
  import evt_timer_pkg::*;
#(
  parameter int NUM_CH  = 3,
  parameter int NUM_IRQ = 24
) (
  input  logic [NUM_CH-1:0]      fire,
  input  logic [NUM_CH-1:0][4:0] route,
  input  logic                   legacy,
  output logic [NUM_IRQ-1:0]     irq
);
  logic [NUM_CH-1:0][4:0] dest;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dest
    if (c == 0) begin : g_leg0
      assign dest[c] = legacy ? LEG_LINE_CH0 : route[c];
    end else if (c == 1) begin : g_leg1
      assign dest[c] = legacy ? LEG_LINE_CH1 : route[c];
    end else begin : g_plain
      assign dest[c] = route[c];
    end
  end

  always_comb begin
    irq = '0;
    for (int l = 0; l < NUM_IRQ; l++) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (fire[c] && (dest[c] == 5'(l))) irq[l] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/evt_timer_regif.sv
module evt_timer_regif
  import evt_timer_pkg::*;
#(
  parameter int          NUM_CH  = 3,
  parameter int          NUM_IRQ = 24,
  parameter logic [31:0] TICK_FS = 32'd10000000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [1:0]         req_size,
  input  logic [9:0]         req_addr,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  output logic [31:0]        rsp_rdata,
  output logic [NUM_IRQ-1:0] irq_pulse,
  output logic               legacy_off
);
  localparam int          CNT_W     = 64;
  localparam logic [31:0] ROUTE_CAP = (NUM_IRQ >= 32) ? 32'hFFFF_FFFF
                                                      : ((32'd1 << NUM_IRQ) - 32'd1);
  localparam logic [31:0] CAP_LO    = {16'h8086, 1'b1, 1'b0, 1'b1, 5'(NUM_CH - 1), 8'h01};

  logic             acc_word;
  logic             wr_word;
  logic             rd_acc;
  logic [9:0]       wa;
  logic             in_ch_area;
  logic [4:0]       ch_idx;
  logic [2:0]       sub;
  logic             ch_hit;
  logic             gctl_we;
  logic             cnt_lo_we;
  logic             cnt_hi_we;
  logic             glb_en;
  logic             glb_legacy;
  logic             en_rise;
  logic             en_fall;
  logic [CNT_W-1:0] count_val;
  logic [31:0]      rd_word;
  logic             rsp_v_q;
  logic [31:0]      rsp_d_q;

  logic [NUM_CH-1:0][31:0]    ch_ctl;
  logic [NUM_CH-1:0][63:0]    ch_cmp;
  logic [NUM_CH-1:0]          ch_fire;
  logic [NUM_CH-1:0][4:0]     ch_route;

  // Request decode
  assign req_ready  = 1'b1;
  assign acc_word   = req_valid && (req_size == SZ_WORD);
  assign wr_word    = acc_word && req_write;
  assign rd_acc     = req_valid && !req_write;
  assign wa         = {req_addr[9:2], 2'b00};
  assign in_ch_area = |req_addr[9:8];
  assign ch_idx     = req_addr[9:5] - CH_SLOT0;
  assign sub        = req_addr[4:2];
  assign ch_hit     = in_ch_area && (ch_idx < 5'(NUM_CH));

  assign gctl_we   = wr_word && !in_ch_area && (wa == OFS_GCTL);
  assign cnt_lo_we = wr_word && !in_ch_area && (wa == OFS_CNT_LO);
  assign cnt_hi_we = wr_word && !in_ch_area && (wa == OFS_CNT_HI);
  assign en_rise   = gctl_we &&  req_wdata[GCTL_EN] && !glb_en;
  assign en_fall   = gctl_we && !req_wdata[GCTL_EN] &&  glb_en;

  // Global control
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en     <= 1'b0;
      glb_legacy <= 1'b0;
    end else if (gctl_we) begin
      glb_en     <= req_wdata[GCTL_EN];
      glb_legacy <= req_wdata[GCTL_LEG];
    end
  end

  assign legacy_off = glb_legacy;

  evt_timer_counter #(.CNT_W(CNT_W)) u_counter (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (glb_en),
    .wr_lo (cnt_lo_we),
    .wr_hi (cnt_hi_we),
    .wdata (req_wdata),
    .count (count_val)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel;
    assign sel = wr_word && ch_hit && (ch_idx == 5'(c));

    evt_timer_channel #(.CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_we    (sel && (sub == SUB_CTL_LO)),
      .cmp_lo_we (sel && (sub == SUB_CMP_LO)),
      .cmp_hi_we (sel && (sub == SUB_CMP_HI)),
      .wdata     (req_wdata),
      .glb_en    (glb_en),
      .en_rise   (en_rise),
      .en_fall   (en_fall),
      .count     (count_val),
      .ctl_word  (ch_ctl[c]),
      .cmp_val   (ch_cmp[c]),
      .fire      (ch_fire[c]),
      .route     (ch_route[c])
    );
  end

  evt_timer_irq_router #(.NUM_CH(NUM_CH), .NUM_IRQ(NUM_IRQ)) u_router (
    .fire   (ch_fire),
    .route  (ch_route),
    .legacy (glb_legacy),
    .irq    (irq_pulse)
  );

  // Read mux
  always_comb begin
    rd_word = '0;
    if (in_ch_area) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (ch_hit && (ch_idx == 5'(c))) begin
          case (sub)
            SUB_CTL_LO: rd_word = ch_ctl[c];
            SUB_CTL_HI: rd_word = ROUTE_CAP;
            SUB_CMP_LO: rd_word = ch_cmp[c][31:0];
            SUB_CMP_HI: rd_word = ch_cmp[c][63:32];
            default:    rd_word = '0;
          endcase
        end
      end
    end else begin
      case (wa)
        OFS_CAP_LO: rd_word = CAP_LO;
        OFS_CAP_HI: rd_word = TICK_FS;
        OFS_GCTL:   rd_word = {30'b0, glb_legacy, glb_en};
        OFS_STAT:   rd_word = '0;
        OFS_CNT_LO: rd_word = count_val[31:0];
        OFS_CNT_HI: rd_word = count_val[63:32];
        default:    rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q <= 1'b0;
      rsp_d_q <= '0;
    end else begin
      rsp_v_q <= rd_acc;
      if (rd_acc) rsp_d_q <= (req_size == SZ_WORD) ? rd_word : 32'd0;
    end
  end

  assign rsp_valid = rsp_v_q;
  assign rsp_rdata = rsp_d_q;
endmodule

// File: rtl/evt_timer_checker.sv
module evt_timer_checker #(
  parameter int NUM_IRQ = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic [1:0]         req_size,
  input logic [9:0]         req_addr,
  input logic [31:0]        req_wdata,
  input logic               rsp_valid,
  input logic [NUM_IRQ-1:0] irq_pulse,
  input logic               legacy_off,
  input logic               glb_en,
  input logic [63:0]        count
);
  logic word_wr;
  logic cnt_wr;
  logic gctl_wr;
  logic narrow_wr;

  assign word_wr   = req_valid && req_write && (req_size == 2'd2);
  assign cnt_wr    = word_wr && ((req_addr[9:2] == 8'h3C) || (req_addr[9:2] == 8'h3D));
  assign gctl_wr   = word_wr && (req_addr[9:2] == 8'h04);
  assign narrow_wr = req_valid && req_write && (req_size != 2'd2);

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);  // R2

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);  // R2

  AST_HALTED_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !cnt_wr) |=> $stable(count));  // R6

  AST_RUNNING_COUNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_en && !cnt_wr) |=> (count == $past(count) + 64'd1));  // R6

  AST_LEGACY_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    gctl_wr |=> (legacy_off == $past(req_wdata[1])));  // R13

  AST_NARROW_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    narrow_wr |=> ($stable(legacy_off) && $stable(glb_en)));  // R4

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_pulse) |-> $past(glb_en));  // R10
endmodule

bind evt_timer_regif evt_timer_checker #(.NUM_IRQ(NUM_IRQ)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_size   (req_size),
  .req_addr   (req_addr),
  .req_wdata  (req_wdata),
  .rsp_valid  (rsp_valid),
  .irq_pulse  (irq_pulse),
  .legacy_off (legacy_off),
  .glb_en     (glb_en),
  .count      (count_val)
);

// File: tb/evt_timer_regif_tb_top.sv
module evt_timer_regif_tb_top;
  localparam int          NIRQ = 24;
  localparam logic [31:0] TICK = 32'd10000000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic            req_write = 1'b0;
  logic [1:0]      req_size = 2'd2;
  logic [9:0]      req_addr = '0;
  logic [31:0]     req_wdata = '0;
  logic            rsp_valid;
  logic [31:0]     rsp_rdata;
  logic [NIRQ-1:0] irq_pulse;
  logic            legacy_off;

  int n_chk = 0;
  int n_fail = 0;
  int nh;
  int hit_cyc [8];
  logic [NIRQ-1:0] hit_val [8];
  logic [31:0] d0, d1;

  always #10 clk = ~clk;

  evt_timer_regif #(.NUM_CH(3), .NUM_IRQ(NIRQ), .TICK_FS(TICK)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .irq_pulse(irq_pulse), .legacy_off(legacy_off)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_size = sz;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_size = 2'd2;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d, input logic [1:0] sz = 2'd2);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
    @(negedge clk);
    d = rsp_rdata;
    req_valid = 1'b0; req_size = 2'd2;
  endtask

  task automatic watch(input int ncyc);
    nh = 0;
    for (int i = 1; i <= ncyc; i++) begin
      @(posedge clk); #1;
      if (|irq_pulse) begin
        if (nh < 8) begin hit_cyc[nh] = i; hit_val[nh] = irq_pulse; end
        nh++;
      end
    end
    @(negedge clk);
  endtask

  function automatic logic [31:0] exp_reset(input int a);
    int slot;
    if (a < 'h100) begin
      case (a)
        'h000:   return 32'h8086A201;
        'h004:   return TICK;
        default: return 32'h0;
      endcase
    end
    slot = (a - 'h100) / 'h20;
    if (slot >= 3) return 32'h0;
    case ((a % 'h20) / 4)
      0:       return 32'h30;
      1:       return 32'h00FFFFFF;
      2, 3:    return 32'hFFFFFFFF;
      default: return 32'h0;
    endcase
  endfunction

  task automatic sweep(input string tag);
    logic [31:0] d;
    for (int a = 0; a < 1024; a += 4) begin
      rd(10'(a), d);
      check($sformatf("%s @0x%0h", tag, a), d, exp_reset(a));
    end
  endtask

  task automatic set_count(input logic [31:0] hi, input logic [31:0] lo);
    wr(10'h0F0, lo);
    wr(10'h0F4, hi);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset outputs and full reset map, R3 unmapped zero
    check("R1 legacy_off at reset", legacy_off, 0);
    check("R1 irq at reset", irq_pulse, 0);
    check("R2 ready high", req_ready, 1);
    sweep("R1 R3 reset map");

    // R3 R4 R8: writes that must change nothing
    wr(10'h010, 32'h3, 2'd0);
    wr(10'h010, 32'h3, 2'd1);
    wr(10'h000, 32'h0);
    wr(10'h004, 32'h0);
    wr(10'h020, 32'hFFFFFFFF);
    wr(10'h014, 32'h3);
    wr(10'h0F8, 32'h5);
    wr(10'h160, 32'hFFFF);
    wr(10'h168, 32'h0);
    wr(10'h3E8, 32'h0);
    wr(10'h104, 32'h0);
    wr(10'h108, 32'h0, 2'd1);
    wr(10'h0F0, 32'h55, 2'd0);
    check("R4 legacy_off after narrow write", legacy_off, 0);
    sweep("R3 R4 R8 map after ignored writes");

    // R2 R4 narrow read responds with zero
    rd(10'h000, d0, 2'd0);
    check("R4 narrow read data", d0, 0);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 10'h000; req_size = 2'd0;
    @(negedge clk);
    check("R2 rsp_valid after read", rsp_valid, 1);
    req_valid = 1'b0; req_size = 2'd2;
    @(negedge clk);
    check("R2 rsp_valid drops", rsp_valid, 0);

    // R5 global control mask
    wr(10'h010, 32'hFFFFFFFC);
    rd(10'h010, d0);
    check("R5 masked control bits", d0, 0);
    wr(10'h010, 32'h2);
    rd(10'h010, d0);
    check("R5 legacy bit writable", d0, 2);
    check("R13 legacy_off set", legacy_off, 1);
    wr(10'h010, 32'h0);
    check("R13 legacy_off cleared", legacy_off, 0);

    // R7 counter halves, R6 halted hold
    wr(10'h0F0, 32'h12345678);
    rd(10'h0F0, d0); rd(10'h0F4, d1);
    check("R7 low half written", d0, 32'h12345678);
    check("R7 high half untouched", d1, 0);
    wr(10'h0F4, 32'h9ABCDEF0);
    rd(10'h0F0, d0); rd(10'h0F4, d1);
    check("R7 low half kept", d0, 32'h12345678);
    check("R7 high half written", d1, 32'h9ABCDEF0);
    repeat (5) @(negedge clk);
    rd(10'h0F0, d0);
    check("R6 halted counter holds", d0, 32'h12345678);

    // R6 running rate
    set_count(32'h0, 32'h0);
    wr(10'h010, 32'h1);
    rd(10'h0F0, d0);
    repeat (9) @(negedge clk);
    rd(10'h0F0, d1);
    check("R6 ten clocks advance ten", d1 - d0, 10);
    wr(10'h010, 32'h0);
    rd(10'h0F0, d0);
    repeat (7) @(negedge clk);
    rd(10'h0F0, d1);
    check("R6 frozen after disable", d1, d0);

    // R9 channel control mask, R14 truncation
    wr(10'h140, 32'hFFFFFFFF);
    rd(10'h140, d0);
    check("R9 channel control mask", d0, 32'h3F7C);
    rd(10'h144, d0);
    check("R9 route capability read-only", d0, 32'h00FFFFFF);
    rd(10'h148, d0);
    check("R14 comparator low kept", d0, 32'hFFFFFFFF);
    rd(10'h14C, d0);
    check("R14 comparator high cleared", d0, 0);
    wr(10'h140, 32'h0);

    // R10 one-shot, interrupt-enable gating, R12 arm on enable
    set_count(32'h0, 32'd100);
    wr(10'h100, 32'h604);
    wr(10'h108, 32'd120); wr(10'h10C, 32'h0);
    wr(10'h120, 32'h000);
    wr(10'h128, 32'd120); wr(10'h12C, 32'h0);
    wr(10'h010, 32'h1);
    watch(60);
    check("R10 one-shot pulse count", nh, 1);
    check("R10 one-shot pulse cycle", hit_cyc[0], 21);
    check("R10 one-shot pulse line", hit_val[0], 24'h8);
    wr(10'h010, 32'h0);

    // R12 disable stops pending match
    set_count(32'h0, 32'h0);
    wr(10'h108, 32'd50);
    wr(10'h010, 32'h1);
    watch(10);
    wr(10'h010, 32'h0);
    watch(60);
    check("R12 no pulse after disable", nh, 0);
    rd(10'h0F0, d0);
    check("R12 counter stopped at disable", d0, 11);

    // R13 legacy routing vs normal routing
    set_count(32'h0, 32'h0);
    wr(10'h108, 32'd7);
    wr(10'h120, 32'h804);
    wr(10'h128, 32'd7);
    wr(10'h010, 32'h3);
    check("R13 legacy_off asserted", legacy_off, 1);
    watch(20);
    check("R13 legacy pulse count", nh, 1);
    check("R13 legacy pulse cycle", hit_cyc[0], 8);
    check("R13 legacy lines 0 and 8", hit_val[0], 24'h101);
    wr(10'h010, 32'h0);
    check("R13 legacy_off released", legacy_off, 0);
    set_count(32'h0, 32'h0);
    wr(10'h010, 32'h1);
    watch(20);
    check("R13 normal route cycle", hit_cyc[0], 8);
    check("R13 normal route lines 3 and 4", hit_val[0], 24'h18);
    wr(10'h010, 32'h0);

    // R11 periodic
    wr(10'h100, 32'h0);
    wr(10'h120, 32'h0);
    set_count(32'h0, 32'h0);
    wr(10'h140, 32'hA4C);
    wr(10'h148, 32'd10);
    rd(10'h140, d0);
    check("R11 set-comparator self clears", d0, 32'hA3C);
    wr(10'h010, 32'h1);
    watch(55);
    check("R11 periodic pulse count", nh, 5);
    for (int k = 0; k < 5; k++) begin
      check($sformatf("R11 periodic pulse %0d cycle", k), hit_cyc[k], 11 + 10 * k);
      check($sformatf("R11 periodic pulse %0d line", k), hit_val[k], 24'h20);
    end
    wr(10'h010, 32'h0);
    rd(10'h148, d0);
    check("R11 comparator advanced", d0, 60);

    // R14 32-bit mode compare
    wr(10'h140, 32'hD04);
    wr(10'h148, 32'd5);
    wr(10'h14C, 32'h77);
    rd(10'h14C, d0);
    check("R14 high comparator write ignored", d0, 0);
    set_count(32'h1, 32'h0);
    wr(10'h010, 32'h1);
    watch(20);
    check("R14 32-bit pulse count", nh, 1);
    check("R14 32-bit pulse cycle", hit_cyc[0], 6);
    check("R14 32-bit pulse line", hit_val[0], 24'h40);
    wr(10'h010, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule